// File: doc/BRIEF.md
# Configuration Power-Up Sequencer

This controller runs the global configuration flow of an SRAM-based programmable device. A power-on-reset input or a low level on the active-low program request starts a configuration-memory clear. The clear is modelled as a counted delay. During the clear the block pulls both the INIT and DONE lines low. When the clear ends it stops pulling INIT. An external open-drain agent may keep INIT low, which delays the next step. The block watches the real pad level. In the cycle where it first sees INIT high, it captures the mode and variant straps and starts the bitstream loader.

The loader answers with a good-result pulse or an error pulse. After a good result, startup runs in a fixed order. First the global set/reset is released, then the global tristate, and then DONE is no longer pulled low. End-of-startup is flagged only once the DONE pad really reads high. An error pulls INIT low again and keeps DONE low until the next restart. A new program-request pulse restarts the flow from the clear phase in any state, user mode included.

INIT and DONE are each given as a drive-low enable plus a pad-level input. The board-level wired-AND is therefore outside the block, and external holds on either line are visible to it.

Top module: `cfg_powerup_seq`

## Requirements
- R1: While `rst`, `por_i` is high or `prog_req_n_i` is low, the cycle that follows shows the clear state. In that state `init_drive_low_o`=1, `done_drive_low_o`=1, `gsr_o`=1, `gts_o`=1, `load_active_o`=0 and `eos_o`=0.
- R2: `init_drive_low_o` stays 1 for CLEAR_CYCLES-1 cycles after the last cycle of a restart request. It reads 0 after the CLEAR_CYCLES-th clock edge.
- R3: The 3-bit mode and 3-bit variant straps are captured in the cycle where `init_pad_i` is first seen high after the clear. The latched values do not change afterwards until the next capture, whatever the strap inputs do.
- R4: While `init_pad_i` reads low after the clear, `load_active_o` stays 0. It reads 1 one cycle after the pad is first seen high.
- R5: After `load_ok_i`, startup runs in three phases of PHASE_CYCLES cycles each. In the first, `gsr_o`=0 and `gts_o`=1. In the second, `gts_o`=0 as well. In the third, `done_drive_low_o`=0.
- R6: `load_err_i` during loading gives `init_drive_low_o`=1, `done_drive_low_o`=1, `gsr_o`=1, `gts_o`=1 and `load_active_o`=0 from the next cycle. These values hold until a restart.
- R7: `done_drive_low_o` is 1 in every state except the third startup phase and user mode.
- R8: `eos_o` rises only after the third startup phase has lasted at least PHASE_CYCLES cycles with `done_pad_i` seen high. An external low hold on DONE delays it.
- R9: A program-request pulse while in user mode returns the block to the clear state of R1.
- R10: If `load_ok_i` and `load_err_i` are both high in the same loading cycle, the error path of R6 is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset active, high |
| prog_req_n_i | input | 1 | Program request, active low |
| init_pad_i | input | 1 | Sampled INIT pad level |
| done_pad_i | input | 1 | Sampled DONE pad level |
| mode_strap_i | input | 3 | Mode strap pins |
| variant_strap_i | input | 3 | Variant strap pins |
| load_ok_i | input | 1 | Loader result: bitstream good |
| load_err_i | input | 1 | Loader result: CRC or configuration error |
| init_drive_low_o | output | 1 | Pull INIT pad low |
| done_drive_low_o | output | 1 | Pull DONE pad low |
| gsr_o | output | 1 | Global set/reset asserted |
| gts_o | output | 1 | Global tristate asserted |
| load_active_o | output | 1 | Bitstream loader enabled |
| eos_o | output | 1 | End of startup |
| mode_latched_o | output | 3 | Captured mode straps |
| variant_latched_o | output | 3 | Captured variant straps |
| | | | |

## Verification
The sequence is tried with several stimulus patterns:
- No INIT hold, which checks that loading starts one cycle after the clear.
- INIT holds of different lengths, during which the straps carry a decoy value that is replaced only in the release cycle. This separates capture at the release edge from capture at the end of the clear.
- Good, error and simultaneous good-plus-error loader results, which separate the startup path from the abort path and show which result wins.
- DONE-line holds of different lengths, which show that end-of-startup waits on the real pad.

Restarts are issued from user mode, from the error state and through the power-on input.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int unsigned STRAP_W = 3;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_WAIT_INIT,
        ST_LOAD,
        ST_REL_GSR,
        ST_REL_GTS,
        ST_REL_DONE,
        ST_USER,
        ST_ERROR
    } seq_state_e;

    typedef struct packed {
        logic [STRAP_W-1:0] mode;
        logic [STRAP_W-1:0] variant;
    } strap_t;

    typedef struct packed {
        logic init_low;
        logic done_low;
        logic gsr;
        logic gts;
        logic load;
        logic eos;
    } ctrl_t;

    function automatic logic is_startup(seq_state_e st);
        return (st == ST_REL_GSR) || (st == ST_REL_GTS) || (st == ST_REL_DONE);
    endfunction

    function automatic ctrl_t decode_ctrl(seq_state_e st, logic eos_en);
        ctrl_t c;
        c = '{init_low: 1'b0, done_low: 1'b1, gsr: 1'b1, gts: 1'b1,
              load: 1'b0, eos: 1'b0};
        case (st)
            ST_CLEAR, ST_ERROR: c.init_low = 1'b1;
            ST_LOAD:            c.load = 1'b1;
            ST_REL_GSR:         c.gsr = 1'b0;
            ST_REL_GTS: begin
                c.gsr = 1'b0;
                c.gts = 1'b0;
            end
            ST_REL_DONE: begin
                c.gsr      = 1'b0;
                c.gts      = 1'b0;
                c.done_low = 1'b0;
            end
            ST_USER: begin
                c.gsr      = 1'b0;
                c.gts      = 1'b0;
                c.done_low = 1'b0;
                c.eos      = eos_en;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch
    import cfg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture_i,
    input  strap_t straps_i,
    output strap_t straps_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            straps_o <= '0;
        end else if (capture_i) begin
            straps_o <= straps_i;
        end
    end

endmodule

// File: rtl/cfg_powerup_seq.sv
module cfg_powerup_seq
    import cfg_seq_pkg::*;
#(
    parameter int unsigned CLEAR_CYCLES = 64,
    parameter int unsigned PHASE_CYCLES = 1,
    parameter bit          EOS_EN       = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por_i,
    input  logic               prog_req_n_i,
    input  logic               init_pad_i,
    input  logic               done_pad_i,
    input  logic [STRAP_W-1:0] mode_strap_i,
    input  logic [STRAP_W-1:0] variant_strap_i,
    input  logic               load_ok_i,
    input  logic               load_err_i,
    output logic               init_drive_low_o,
    output logic               done_drive_low_o,
    output logic               gsr_o,
    output logic               gts_o,
    output logic               load_active_o,
    output logic               eos_o,
    output logic [STRAP_W-1:0] mode_latched_o,
    output logic [STRAP_W-1:0] variant_latched_o
);
    seq_state_e state_q;
    ctrl_t      ctrl;
    strap_t     strap_in, strap_q;
    logic       restart_req, clear_done, phase_exp, phase_step, capture;

    assign restart_req = por_i || !prog_req_n_i;
    assign capture     = (state_q == ST_WAIT_INIT) && init_pad_i && !restart_req;
    assign phase_step  = is_startup(state_q) && phase_exp &&
                         ((state_q != ST_REL_DONE) || done_pad_i);

    cfg_cycle_timer #(.LIMIT(CLEAR_CYCLES)) u_clear_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_req),
        .run_i     (state_q == ST_CLEAR),
        .expired_o (clear_done)
    );

    cfg_cycle_timer #(.LIMIT(PHASE_CYCLES)) u_phase_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_req || !is_startup(state_q) || phase_step),
        .run_i     (is_startup(state_q)),
        .expired_o (phase_exp)
    );

    assign strap_in = '{mode: mode_strap_i, variant: variant_strap_i};

    cfg_strap_latch u_strap_latch (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .straps_i  (strap_in),
        .straps_o  (strap_q)
    );

    always_ff @(posedge clk) begin
        if (rst || restart_req) begin
            state_q <= ST_CLEAR;
        end else begin
            case (state_q)
                ST_CLEAR:     if (clear_done) state_q <= ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_pad_i) state_q <= ST_LOAD;
                ST_LOAD: begin
                    if (load_err_i)     state_q <= ST_ERROR;
                    else if (load_ok_i) state_q <= ST_REL_GSR;
                end
                ST_REL_GSR:   if (phase_step) state_q <= ST_REL_GTS;
                ST_REL_GTS:   if (phase_step) state_q <= ST_REL_DONE;
                ST_REL_DONE:  if (phase_step) state_q <= ST_USER;
                default:      state_q <= state_q;
            endcase
        end
    end

    assign ctrl              = decode_ctrl(state_q, EOS_EN);
    assign init_drive_low_o  = ctrl.init_low;
    assign done_drive_low_o  = ctrl.done_low;
    assign gsr_o             = ctrl.gsr;
    assign gts_o             = ctrl.gts;
    assign load_active_o     = ctrl.load;
    assign eos_o             = ctrl.eos;
    assign mode_latched_o    = strap_q.mode;
    assign variant_latched_o = strap_q.variant;

    // R1: a restart request forces the clear outputs on the next cycle
    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> (init_drive_low_o && done_drive_low_o && gsr_o && gts_o && !eos_o));

    // R3: latched straps move only out of the wait-for-INIT state
    assert_straps_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_WAIT_INIT) |=> $stable(strap_q));

    // R4: a held-low INIT pad keeps the loader idle
    assert_init_hold_stalls_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_INIT && !init_pad_i && !restart_req) |=> !load_active_o);

    // R5: the tristate is released only with set/reset already released
    assert_gts_after_gsr_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(gts_o) |-> (!gsr_o && $past(!gsr_o)));

    // R6: an error aborts with INIT and DONE both pulled low
    assert_error_aborts_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && load_err_i && !restart_req) |=>
        (init_drive_low_o && done_drive_low_o && !load_active_o));

    // R7: DONE is released only after both globals are released
    assert_done_last_R7: assert property (@(posedge clk) disable iff (rst)
        !done_drive_low_o |-> (!gts_o && !gsr_o));

    // R8: end-of-startup needs the DONE pad seen high
    assert_eos_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(eos_o) |-> $past(done_pad_i));

endmodule

// File: tb/cfg_powerup_seq_tb.sv
module cfg_powerup_seq_tb;
    localparam int CLR = 12;
    localparam int PH  = 2;

    logic clk = 1'b0;
    logic rst, por, prog_n, init_hold, done_hold, load_ok, load_err;
    logic [2:0] mode_s, var_s, mode_l, var_l;
    logic init_dl, done_dl, gsr, gts, load_act, eos;
    logic init_pad, done_pad;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign init_pad = !init_dl && !init_hold;
    assign done_pad = !done_dl && !done_hold;

    cfg_powerup_seq #(.CLEAR_CYCLES(CLR), .PHASE_CYCLES(PH), .EOS_EN(1'b1)) u_dut (
        .clk               (clk),
        .rst               (rst),
        .por_i             (por),
        .prog_req_n_i      (prog_n),
        .init_pad_i        (init_pad),
        .done_pad_i        (done_pad),
        .mode_strap_i      (mode_s),
        .variant_strap_i   (var_s),
        .load_ok_i         (load_ok),
        .load_err_i        (load_err),
        .init_drive_low_o  (init_dl),
        .done_drive_low_o  (done_dl),
        .gsr_o             (gsr),
        .gts_o             (gts),
        .load_active_o     (load_act),
        .eos_o             (eos),
        .mode_latched_o    (mode_l),
        .variant_latched_o (var_l)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // {mode, variant, init hold cycles, result 0 ok 1 err 2 both, done hold cycles}
    localparam logic [14:0] VEC [5] = '{
        {3'b001, 3'b111, 4'd0, 2'd0, 3'd0},
        {3'b010, 3'b101, 4'd3, 2'd0, 3'd2},
        {3'b110, 3'b011, 4'd0, 2'd1, 3'd0},
        {3'b101, 3'b000, 4'd5, 2'd2, 3'd0},
        {3'b111, 3'b110, 4'd1, 2'd0, 3'd4}
    };

    task automatic run_case(input logic [2:0] m, input logic [2:0] v, input int hold,
                            input int res, input int dh);
        @(negedge clk);
        prog_n    = 1'b0;
        init_hold = (hold != 0);
        done_hold = (dh != 0);
        mode_s    = (hold != 0) ? ~m : m;
        var_s     = (hold != 0) ? ~v : v;
        @(negedge clk);
        chk("R1 R9 init low", {7'd0, init_dl}, 8'd1);
        chk("R1 R9 done/gsr/gts/load/eos", {3'd0, done_dl, gsr, gts, load_act, eos}, 8'b0001_1100);
        @(negedge clk);
        prog_n = 1'b1;
        repeat (CLR - 1) @(negedge clk);
        chk("R2 init still driven", {7'd0, init_dl}, 8'd1);
        @(negedge clk);
        chk("R2 init released", {7'd0, init_dl}, 8'd0);
        if (hold != 0) begin
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk("R4 loader idle while held", {7'd0, load_act}, 8'd0);
            end
            init_hold = 1'b0;
            mode_s    = m;
            var_s     = v;
        end
        @(negedge clk);
        chk("R4 loading after INIT high", {7'd0, load_act}, 8'd1);
        chk("R3 straps captured", {2'd0, mode_l, var_l}, {2'd0, m, v});
        mode_s = ~m;
        var_s  = ~v;
        @(negedge clk);
        chk("R3 straps not resampled", {2'd0, mode_l, var_l}, {2'd0, m, v});
        load_err = (res != 0);
        load_ok  = (res != 1);
        @(negedge clk);
        load_err = 1'b0;
        load_ok  = 1'b0;
        if (res != 0) begin
            chk(res == 2 ? "R10 error wins" : "R6 error abort",
                {3'd0, init_dl, done_dl, gsr, gts, load_act}, 8'b0001_1110);
            repeat (3) @(negedge clk);
            chk("R6 error held", {5'd0, init_dl, done_dl, eos}, 8'b0000_0110);
        end else begin
            for (int i = 0; i < PH; i++) begin
                chk("R5 gsr phase", {5'd0, gsr, gts, done_dl}, 8'b0000_0011);
                @(negedge clk);
            end
            for (int i = 0; i < PH; i++) begin
                chk("R5 R7 gts phase", {5'd0, gsr, gts, done_dl}, 8'b0000_0001);
                @(negedge clk);
            end
            for (int i = 0; i < PH + dh; i++) begin
                chk("R8 done released, no eos yet", {6'd0, done_dl, eos}, 8'd0);
                @(negedge clk);
            end
            done_hold = 1'b0;
            if (dh != 0) @(negedge clk);
            chk("R8 eos in user mode", {7'd0, eos}, 8'd1);
        end
    endtask

    initial begin
        rst = 1'b1; por = 1'b0; prog_n = 1'b1; init_hold = 1'b0; done_hold = 1'b0;
        load_ok = 1'b0; load_err = 1'b0; mode_s = '0; var_s = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", {2'd0, init_dl, done_dl, gsr, gts, load_act, eos}, 8'b0011_1100);
        chk("R3 reset straps", {2'd0, mode_l, var_l}, 8'd0);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            run_case(VEC[k][14:12], VEC[k][11:9], int'(VEC[k][8:5]),
                     int'(VEC[k][4:3]), int'(VEC[k][2:0]));
        end
        // R1: power-on reset from user mode
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        chk("R1 por clears", {2'd0, init_dl, done_dl, gsr, gts, load_act, eos}, 8'b0011_1100);
        por = 1'b0;
        // R4: a result pulse outside loading is ignored; still clearing
        load_ok = 1'b1;
        @(negedge clk);
        load_ok = 1'b0;
        chk("R4 ok outside load ignored", {6'd0, init_dl, gsr}, 8'b0000_0011);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule